// File: doc/BRIEF.md
# DMA Completion-Pointer Interrupt Controller

This block raises one completion interrupt for each of eight DMA channels. When the DMA engine finishes a packet, it writes the address of that packet's last descriptor into the channel's completion pointer. The block stores that address and marks the channel pending, whatever address was written. The host acknowledges a channel by writing a descriptor address to the same pointer location. That host write is only compared with the stored address and never changes it. The pending state clears only when the two are equal. A host that has drained several packets in one pass therefore clears the interrupt only when it writes the newest address. Older addresses leave the interrupt asserted.

Each channel is a two-state machine. The states are `CH_IDLE` (nothing outstanding) and `CH_PEND` (interrupt level asserted). It has three named transitions:
- `T_ARM`: an engine write moves the channel from `CH_IDLE` to `CH_PEND`.
- `T_HOLD`: the channel stays in `CH_PEND` on another engine write or on a mismatching acknowledge.
- `T_ACK`: a matching acknowledge with no engine write in the same cycle moves the channel from `CH_PEND` to `CH_IDLE`.

An acknowledge in `CH_IDLE` has no effect.

A shared enable mask gates the pending bits. The mask is changed through a set-style register and a clear-style register. The masked bits drive eight per-channel lines and one combined request. The host reads everything over a simple register bus with a combinational read port.

Top module: `dma_cmpl_irq`

## Requirements
- R1: After reset, every completion pointer reads 0, the mask reads 0, the raw and masked status read 0, and `irq` and `irq_lines` are low.
- R2: When `eng_we[n]` is high at a clock edge, channel n stores `eng_ptr` and is raw-pending from that edge on, for any value including zero.
- R3: A host write to word address 8+n whose data equals channel n's stored pointer clears channel n's raw pending bit at that edge. The same write to a channel that is not pending has no effect.
- R4: A host write to word address 8+n whose data differs from the stored pointer leaves channel n pending.
- R5: A host write never changes a stored pointer. A read of word address 8+n returns the last value the engine wrote.
- R6: A host write to word address 0 (mask set) sets each mask bit n for which data bit n is 1. Zero bits and data bits at position 8 or above have no effect. A read of address 0 returns the mask.
- R7: A host write to word address 1 (mask clear) clears each mask bit n for which data bit n is 1 and leaves the others unchanged. A read of address 1 returns the mask.
- R8: A read of word address 2 returns the raw pending vector, with bit n for channel n. A read of address 3 returns the raw vector ANDed with the mask. `irq_lines` equals that masked vector. Masking never changes the raw vector.
- R9: `irq` is high exactly when any masked status bit is 1.
- R10: When an engine write and a host acknowledge reach the same channel in the same cycle, the engine write wins. The channel stays pending and stores the engine value.
- R11: After several engine writes, an acknowledge with an older pointer leaves the channel pending. Only the newest pointer clears it.
- R12: Host writes to word addresses 2, 3 and any unmapped address change no state. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host word address for read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for `host_addr` |
| eng_we | input | 8 | Engine completion-pointer write strobe, one per channel |
| eng_ptr | input | 32 | Engine descriptor address, shared by the strobes |
| irq | output | 1 | OR of all masked status bits |
| irq_lines | output | 8 | Per-channel masked interrupt lines |

## Verification
Every register update in the block takes effect at the clock edge that samples the write. This covers engine writes, acknowledges and mask writes. The status, `irq_lines` and `irq` therefore reflect a stimulus one edge after it is driven, and the read port reflects the new state in that same cycle. The bench drives inputs a quarter period after each rising edge and updates its reference model on the rising edge. It compares every output and the read data at the falling edge. Each comparison therefore sees the design one edge after its inputs, which matches the single-edge latency of every path.

// File: rtl/dcpi_pkg.sv
package dcpi_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_t;

    localparam int unsigned A_MSET     = 0;
    localparam int unsigned A_MCLR     = 1;
    localparam int unsigned A_RAW      = 2;
    localparam int unsigned A_MSK      = 3;
    localparam int unsigned A_PTR_BASE = 8;

endpackage

// File: rtl/dcpi_chan.sv
module dcpi_chan
    import dcpi_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_we,
    input  logic [PTR_W-1:0] eng_ptr,
    input  logic             ack_we,
    input  logic [PTR_W-1:0] ack_ptr,
    output logic             pend,
    output logic [PTR_W-1:0] ptr
);

    ch_state_t        st_q, st_d;
    logic [PTR_W-1:0] ptr_q;
    logic             ack_match;

    assign ack_match = ack_we && (ack_ptr == ptr_q);

    // next state: T_ARM, T_HOLD, T_ACK
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: if (eng_we) st_d = CH_PEND;
            CH_PEND: begin
                if (eng_we)         st_d = CH_PEND;
                else if (ack_match) st_d = CH_IDLE;
                else                st_d = CH_PEND;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // stored pointer: engine writes only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (eng_we) ptr_q <= eng_ptr;
    end

    // outputs
    always_comb begin
        pend = (st_q == CH_PEND);
        ptr  = ptr_q;
    end

    a_r2_engine_arms: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> (pend && ptr == $past(eng_ptr)));

    a_r3_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && !eng_we && ack_ptr == ptr) |=> !pend);

    a_r4_mismatch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ack_we && ack_ptr != ptr) |=> pend);

    a_r5_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_we |=> $stable(ptr));

    a_r10_engine_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && ack_we) |=> pend);

endmodule

// File: rtl/dcpi_mask.sv
module dcpi_mask #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_we,
    input  logic           clr_we,
    input  logic [NCH-1:0] bits,
    output logic [NCH-1:0] mask
);

    logic [NCH-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask_q <= '0;
        else if (set_we) mask_q <= mask_q | bits;
        else if (clr_we) mask_q <= mask_q & ~bits;
    end

    assign mask = mask_q;

    a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask & $past(bits)) == $past(bits)));

    a_r6_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((mask & $past(mask)) == $past(mask)));

    a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask & $past(bits)) == '0));

    a_r7_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        !set_we |=> ((mask & ~$past(mask)) == '0));

endmodule

// File: rtl/dcpi_rdmux.sv
module dcpi_rdmux
    import dcpi_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int PTR_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NCH-1:0]              mask,
    input  logic [NCH-1:0]              raw,
    input  logic [NCH-1:0][PTR_W-1:0]   ptrs,
    output logic [PTR_W-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_MSET) || addr == ADDR_W'(A_MCLR))
            rdata[NCH-1:0] = mask;
        else if (addr == ADDR_W'(A_RAW))
            rdata[NCH-1:0] = raw;
        else if (addr == ADDR_W'(A_MSK))
            rdata[NCH-1:0] = raw & mask;
        else begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == ADDR_W'(A_PTR_BASE + i)) rdata = ptrs[i];
            end
        end
    end

endmodule

// File: rtl/dma_cmpl_irq.sv
module dma_cmpl_irq
    import dcpi_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int PTR_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [PTR_W-1:0]  host_wdata,
    output logic [PTR_W-1:0]  host_rdata,
    input  logic [NCH-1:0]    eng_we,
    input  logic [PTR_W-1:0]  eng_ptr,
    output logic              irq,
    output logic [NCH-1:0]    irq_lines
);

    localparam int MAP_TOP = A_PTR_BASE + NCH;

    logic [NCH-1:0]            raw;
    logic [NCH-1:0]            mask;
    logic [NCH-1:0][PTR_W-1:0] ptrs;
    logic                      set_we, clr_we;

    assign set_we = host_we && (host_addr == ADDR_W'(A_MSET));
    assign clr_we = host_we && (host_addr == ADDR_W'(A_MCLR));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ack_we;
        assign ack_we = host_we && (host_addr == ADDR_W'(A_PTR_BASE + g));
        dcpi_chan #(.PTR_W(PTR_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .eng_we  (eng_we[g]),
            .eng_ptr (eng_ptr),
            .ack_we  (ack_we),
            .ack_ptr (host_wdata),
            .pend    (raw[g]),
            .ptr     (ptrs[g])
        );
    end

    dcpi_mask #(.NCH(NCH)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (set_we),
        .clr_we (clr_we),
        .bits   (host_wdata[NCH-1:0]),
        .mask   (mask)
    );

    dcpi_rdmux #(.NCH(NCH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_rd (
        .addr  (host_addr),
        .mask  (mask),
        .raw   (raw),
        .ptrs  (ptrs),
        .rdata (host_rdata)
    );

    assign irq_lines = raw & mask;
    assign irq       = |irq_lines;

    initial begin
        a_map_fits: assert (MAP_TOP <= (1 << ADDR_W));
    end

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == '0) |-> !irq);

    a_r8_mask_keeps_raw: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_we || clr_we) && eng_we == '0) |=> (raw & ~$past(raw)) == '0);

endmodule

// File: tb/dma_cmpl_irq_bench.sv
module dma_cmpl_irq_bench;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_addr = 4'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [7:0]  eng_we = '0;
    logic [31:0] eng_ptr = '0;
    logic        irq;
    logic [7:0]  irq_lines;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_ptr [NCH];
    logic [7:0]  m_raw;
    logic [7:0]  m_mask;

    always #10 clk = ~clk;

    dma_cmpl_irq u_dma_cmpl_irq (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_we(eng_we),
        .eng_ptr(eng_ptr), .irq(irq), .irq_lines(irq_lines)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(input logic [3:0] a);
        logic [31:0] r = '0;
        if (a == 4'd0 || a == 4'd1) r[7:0] = m_mask;
        else if (a == 4'd2)         r[7:0] = m_raw;
        else if (a == 4'd3)         r[7:0] = m_raw & m_mask;
        else if (a >= 4'd8)         r = m_ptr[a - 4'd8];
        return r;
    endfunction

    // reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) m_ptr[i] = '0;
            m_raw  = '0;
            m_mask = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (eng_we[i]) begin
                    m_ptr[i] = eng_ptr;
                    m_raw[i] = 1'b1;
                end else if (host_we && host_addr == 4'(8 + i) && host_wdata == m_ptr[i]) begin
                    m_raw[i] = 1'b0;
                end
            end
            if (host_we && host_addr == 4'd0) m_mask = m_mask | host_wdata[7:0];
            if (host_we && host_addr == 4'd1) m_mask = m_mask & ~host_wdata[7:0];
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 irq_lines", {24'd0, irq_lines}, {24'd0, m_raw & m_mask});
            check("R9 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
            check("R5/R8/R12 rdata", host_rdata, model_rd(host_addr));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        cyc();
        host_we = 1'b0;
    endtask

    task automatic eng(input logic [7:0] m, input logic [31:0] p);
        eng_we = m; eng_ptr = p;
        cyc();
        eng_we = '0;
    endtask

    task automatic chk_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        host_addr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        // R1 reset state
        chk_rd("R1 raw", 4'd2, 32'h0);
        chk_rd("R1 mask", 4'd0, 32'h0);
        chk_rd("R1 ptr0", 4'd8, 32'h0);
        chk_rd("R1 ptr7", 4'd15, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'h0);
        // R2 engine write arms channel 3
        eng(8'h08, 32'h1000);
        chk_rd("R2 raw", 4'd2, 32'h08);
        chk_rd("R2 ptr3", 4'd11, 32'h1000);
        check("R8 masked line off", {24'd0, irq_lines}, 32'h0);
        // R6 mask set, high bits ignored
        wr(4'd0, 32'h0000_F0F8);
        chk_rd("R6 mask", 4'd0, 32'h0F8);
        check("R9 irq on", {31'd0, irq}, 32'h1);
        chk_rd("R8 masked", 4'd3, 32'h08);
        wr(4'd0, 32'h01);
        chk_rd("R6 zero bits", 4'd1, 32'hF9);
        // R11 multiple packets
        eng(8'h08, 32'h2000);
        wr(4'd11, 32'h1000);
        chk_rd("R11 older ptr holds", 4'd2, 32'h08);
        chk_rd("R5 ptr unchanged", 4'd11, 32'h2000);
        wr(4'd11, 32'h1234);
        chk_rd("R4 mismatch holds", 4'd2, 32'h08);
        wr(4'd11, 32'h2000);
        chk_rd("R3 match clears", 4'd2, 32'h00);
        check("R9 irq off", {31'd0, irq}, 32'h0);
        chk_rd("R5 ptr after ack", 4'd11, 32'h2000);
        // R2 zero value still arms
        eng(8'h01, 32'h0);
        chk_rd("R2 zero value", 4'd2, 32'h01);
        // R7 mask clear
        wr(4'd1, 32'h01);
        chk_rd("R7 mask", 4'd1, 32'hF8);
        chk_rd("R8 raw kept", 4'd2, 32'h01);
        check("R9 masked off", {31'd0, irq}, 32'h0);
        // R10 collision
        host_we = 1'b1; host_addr = 4'd8; host_wdata = 32'h0;
        eng_we = 8'h01; eng_ptr = 32'h55;
        cyc();
        host_we = 1'b0; eng_we = '0;
        chk_rd("R10 stays pending", 4'd2, 32'h01);
        chk_rd("R10 engine value", 4'd8, 32'h55);
        wr(4'd8, 32'h55);
        chk_rd("R3 clear ch0", 4'd2, 32'h00);
        wr(4'd8, 32'h55);
        chk_rd("R3 idle ack no effect", 4'd2, 32'h00);
        // R12 writes to read-only/unmapped
        wr(4'd2, 32'hFF);
        wr(4'd3, 32'hFF);
        wr(4'd5, 32'hFF);
        chk_rd("R12 raw", 4'd2, 32'h00);
        chk_rd("R12 mask", 4'd0, 32'hF8);
        chk_rd("R12 unmapped reads 0", 4'd5, 32'h0);
        // mixed traffic, compared every clock
        for (int k = 0; k < 400; k++) begin
            int sel;
            int ch;
            sel = $urandom_range(0, 9);
            ch  = $urandom_range(0, 7);
            eng_we  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            eng_ptr = $urandom;
            host_we = 1'b1;
            if (sel < 4) begin
                host_addr = 4'(8 + ch); host_wdata = m_ptr[ch];
            end else if (sel < 5) begin
                host_addr = 4'(8 + ch); host_wdata = $urandom;
            end else if (sel < 6) begin
                host_addr = 4'd0; host_wdata = $urandom;
            end else if (sel < 7) begin
                host_addr = 4'd1; host_wdata = $urandom;
            end else begin
                host_we = 1'b0; host_addr = 4'($urandom); host_wdata = $urandom;
            end
            cyc();
        end
        host_we = 1'b0; eng_we = '0;
        cyc();
        summary();
        $finish;
    end

endmodule